// File: doc/BRIEF.md
# Four-Channel Match Timer with Watchdog

This block is an operating-system timer for a processor subsystem. It holds one 32-bit up-counter that advances by one on every clock cycle in which a tick-enable input is high. Four 32-bit compare registers watch the counter. When the counter steps onto a compare value, that channel can record a sticky status flag and hold its own interrupt line high until software clears the flag.

Software reaches the block over a plain register bus. The bus has an address, write data, a write strobe and a read-data return, and reads return data in the same cycle. Compare channel 3 can also serve as a watchdog. If software has armed the watchdog and never moves the compare value or the counter away, the channel 3 match drives a one-cycle system reset request and then disarms itself.

Top module: `match_timer`

## Requirements
- R1: After reset every register reads zero, all four interrupt lines are low and the reset request is low.
- R2: The counter (word offset 0x10) increases by exactly one on each cycle with tickEn high and holds its value on cycles with tickEn low.
- R3: A bus write to the counter loads the written value, and counting resumes from it. When the write and a tick fall in the same cycle, the loaded value is kept and that tick is lost.
- R4: Compare register i sits at byte offset 4*i (i = 0..3). Channel i fires on the clock edge at which the counter takes on a value equal to compare register i, whether by a tick or by a bus load. If bit i of the interrupt-enable register is set, the edge sets status bit i and raises chIrq[i], which is already high in the cycle in which the counter reads the matching value.
- R5: A channel that fires while its interrupt-enable bit is clear records nothing. Setting the enable bit later does not raise that status bit.
- R6: Status (offset 0x14, bits 3..0 = channels 3..0) is write-one-to-clear. Each bit written as 1 is cleared and lowers chIrq of its channel, while bits written as 0 stay set. A new match in the same cycle as a clear leaves the bit set.
- R7: The interrupt-enable register (offset 0x1C) stores only bits 11..0 of a write. Reads return those bits, with bits 31..12 reading zero. Bits 3..0 gate channels 3..0.
- R8: The watchdog register sits at offset 0x18 and reads back the stored word. When channel 3 fires while bit 0 of this register is set, the register clears to zero on that edge and resetReq is high for exactly one cycle. This happens whatever the interrupt-enable bit of channel 3 holds.
- R9: A watchdog register whose bit 0 is clear produces no reset request when channel 3 fires.
- R10: Compare values use 32-bit wraparound. A compare value below the counter fires after the counter passes 0xFFFFFFFF and wraps to 0.
- R11: Reads from any address other than the eight word offsets 0x00..0x1C return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Counter advance enable |
| busAddr | input | ADDR_W (8) | Byte address of the register access |
| busWdata | input | CNT_W (32) | Write data |
| busWe | input | 1 | Write strobe |
| busRdata | output | CNT_W (32) | Read data for busAddr, same cycle |
| chIrq | output | 4 | Per-channel interrupt lines, one per status bit |
| resetReq | output | 1 | One-cycle system reset request from the watchdog |

## Verification
The bench builds the block with its defaults: a 32-bit counter, an 8-bit address and a 12-bit interrupt-enable register. With the full 32-bit counter, the wraparound case is reached by loading the counter just below 0xFFFFFFFF and ticking three times, so no long count is needed. The 8-bit address leaves the offsets from 0x20 up, and misaligned byte addresses, free to probe the unmapped-access behaviour.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;
  localparam int NCH      = 4;
  localparam int CH_IDX_W = $clog2(NCH);
  localparam int WDOG_CH  = 3;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_MATCH,
    RD_CNT,
    RD_STAT,
    RD_WDOG,
    RD_IEN
  } rdSel_e;

  typedef struct packed {
    logic [NCH-1:0]      wrMatch;
    logic                wrCnt;
    logic                wrStat;
    logic                wrWdog;
    logic                wrIen;
    rdSel_e              rdSel;
    logic [CH_IDX_W-1:0] chIdx;
  } busStrb_t;
endpackage

// File: rtl/match_timer_ctrl.sv
module match_timer_ctrl
  import match_timer_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output busStrb_t          strb
);
  localparam int WORD_LSB = 2;
  localparam int MAP_TOP  = 5;

  logic       mapped;
  logic [2:0] wordIdx;

  assign mapped  = (busAddr[WORD_LSB-1:0] == '0) && ((busAddr >> MAP_TOP) == '0);
  assign wordIdx = busAddr[MAP_TOP-1:WORD_LSB];

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_NONE;
    strb.chIdx = wordIdx[CH_IDX_W-1:0];
    if (mapped) begin
      if (wordIdx[2] == 1'b0) begin
        strb.rdSel = RD_MATCH;
        strb.wrMatch[wordIdx[CH_IDX_W-1:0]] = busWe;
      end else begin
        unique case (wordIdx[1:0])
          2'd0: begin strb.rdSel = RD_CNT;  strb.wrCnt  = busWe; end
          2'd1: begin strb.rdSel = RD_STAT; strb.wrStat = busWe; end
          2'd2: begin strb.rdSel = RD_WDOG; strb.wrWdog = busWe; end
          default: begin strb.rdSel = RD_IEN; strb.wrIen = busWe; end
        endcase
      end
    end
  end
endmodule

// File: rtl/match_timer_dp.sv
module match_timer_dp
  import match_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int IEN_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  busStrb_t         strb,
  input  logic [CNT_W-1:0] busWdata,
  output logic [CNT_W-1:0] busRdata,
  output logic [NCH-1:0]   chIrq,
  output logic             resetReq,
  output logic [CNT_W-1:0] cntQ,
  output logic [NCH-1:0]   statQ,
  output logic [IEN_W-1:0] ienQ,
  output logic [CNT_W-1:0] wdogQ
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] matchQ [NCH];
  logic [CNT_W-1:0] cntNext;
  logic             cntMoves;
  logic [NCH-1:0]   hit;
  logic [NCH-1:0]   clrMask;
  logic             reqQ;

  assign cntMoves = strb.wrCnt | tickEn;
  assign cntNext  = strb.wrCnt ? busWdata : (tickEn ? cntQ + ONE : cntQ);

  // One comparator and one compare register per channel
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    assign hit[ch] = cntMoves && (cntNext == matchQ[ch]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                matchQ[ch] <= '0;
      else if (strb.wrMatch[ch]) matchQ[ch] <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntQ <= '0;
    else       cntQ <= cntNext;
  end

  assign clrMask = strb.wrStat ? busWdata[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statQ <= '0;
    else       statQ <= (statQ & ~clrMask) | (hit & ienQ[NCH-1:0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          ienQ <= '0;
    else if (strb.wrIen) ienQ <= busWdata[IEN_W-1:0];
  end

  // Watchdog: a channel-3 hit with bit 0 armed disarms and pulses the request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdogQ <= '0;
      reqQ  <= 1'b0;
    end else if (hit[WDOG_CH] && wdogQ[0]) begin
      wdogQ <= '0;
      reqQ  <= 1'b1;
    end else begin
      if (strb.wrWdog) wdogQ <= busWdata;
      reqQ <= 1'b0;
    end
  end

  assign resetReq = reqQ;
  assign chIrq    = statQ;

  always_comb begin
    unique case (strb.rdSel)
      RD_MATCH: busRdata = matchQ[strb.chIdx];
      RD_CNT:   busRdata = cntQ;
      RD_STAT:  busRdata = {{(CNT_W-NCH){1'b0}}, statQ};
      RD_WDOG:  busRdata = wdogQ;
      RD_IEN:   busRdata = {{(CNT_W-IEN_W){1'b0}}, ienQ};
      default:  busRdata = '0;
    endcase
  end
endmodule

// File: rtl/match_timer.sv
module match_timer
  import match_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32,
  parameter int IEN_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  input  logic              busWe,
  output logic [CNT_W-1:0]  busRdata,
  output logic [NCH-1:0]    chIrq,
  output logic              resetReq
);
  busStrb_t         strb;
  logic [CNT_W-1:0] cntQ;
  logic [NCH-1:0]   statQ;
  logic [IEN_W-1:0] ienQ;
  logic [CNT_W-1:0] wdogQ;

  match_timer_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strb    (strb)
  );

  match_timer_dp #(.CNT_W(CNT_W), .IEN_W(IEN_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .strb     (strb),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .chIrq    (chIrq),
    .resetReq (resetReq),
    .cntQ     (cntQ),
    .statQ    (statQ),
    .ienQ     (ienQ),
    .wdogQ    (wdogQ)
  );
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32,
  parameter int IEN_W  = 12,
  parameter int NCH    = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [CNT_W-1:0]  busWdata,
  input logic              busWe,
  input logic              resetReq,
  input logic [CNT_W-1:0]  cntQ,
  input logic [NCH-1:0]    statQ,
  input logic [IEN_W-1:0]  ienQ,
  input logic [CNT_W-1:0]  wdogQ
);
  logic cntWr, statWr;
  assign cntWr  = busWe && (busAddr == ADDR_W'(16));
  assign statWr = busWe && (busAddr == ADDR_W'(20));

  // R2: counter holds without a tick or a load
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !cntWr) |=> $stable(cntQ));

  // R2: counter steps by one on a tick
  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !cntWr) |=> (cntQ == $past(cntQ) + CNT_W'(1)));

  // R3: a load takes the written value
  a_r3_load: assert property (@(posedge clk) disable iff (!rstN)
    cntWr |=> (cntQ == $past(busWdata)));

  // R8: request lasts one cycle
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  // R8: request comes with a disarmed watchdog
  a_r8_disarm: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> (wdogQ == '0));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
    // R5: a status bit rises only while its enable bit was set
    a_r5_gated: assert property (@(posedge clk) disable iff (!rstN)
      $rose(statQ[ch]) |-> $past(ienQ[ch]));

    // R6: a set bit stays set unless written with a one
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
      (statQ[ch] && !(statWr && busWdata[ch])) |=> statQ[ch]);
  end
endmodule

bind match_timer match_timer_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .IEN_W(IEN_W), .NCH(match_timer_pkg::NCH)
) u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr),
  .busWdata(busWdata), .busWe(busWe), .resetReq(resetReq),
  .cntQ(cntQ), .statQ(statQ), .ienQ(ienQ), .wdogQ(wdogQ)
);

// File: tb/match_timer_test.sv
`timescale 1ns/1ps
module match_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWe = 1'b0;
  logic [31:0] busRdata;
  logic [3:0]  chIrq;
  logic        resetReq;

  int nChk = 0;
  int nFail = 0;
  int pulseCycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  match_timer uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr),
    .busWdata(busWdata), .busWe(busWe), .busRdata(busRdata),
    .chIrq(chIrq), .resetReq(resetReq)
  );

  always @(negedge clk) if (resetReq) pulseCycles++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; tickEn = 1'b0; busWe = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    doReset();
    for (int a = 0; a < 32; a += 4) begin
      rd(8'(a), v);
      chk("R1 reg", v, 0);
    end
    chk("R1 irq", {28'b0, chIrq}, 0);
    chk("R1 req", {31'b0, resetReq}, 0);
  endtask

  task automatic t_count();
    logic [31:0] v;
    doReset();
    tick(5);
    rd(8'h10, v); chk("R2 step", v, 5);
    repeat (3) @(negedge clk);
    rd(8'h10, v); chk("R2 hold", v, 5);
  endtask

  task automatic t_load();
    logic [31:0] v;
    doReset();
    wr(8'h10, 32'h0000_1000);
    tick(2);
    rd(8'h10, v); chk("R3 continue", v, 32'h1002);
    @(negedge clk);
    tickEn = 1'b1; busAddr = 8'h10; busWdata = 32'h0000_2000; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
    @(negedge clk);
    tickEn = 1'b0;
    rd(8'h10, v); chk("R3 load beats tick", v, 32'h2001);
  endtask

  task automatic t_match();
    logic [31:0] v;
    doReset();
    wr(8'h1C, 32'hF);
    wr(8'h10, 10);
    wr(8'h00, 12);
    wr(8'h04, 50);
    tick(1);
    chk("R4 before match", {28'b0, chIrq}, 0);
    tick(1);
    rd(8'h10, v); chk("R4 counter at match", v, 12);
    chk("R4 irq0 with counter", {28'b0, chIrq}, 4'b0001);
    rd(8'h14, v); chk("R4 status0", v, 1);
    rd(8'h04, v); chk("R4 match1 readback", v, 50);
    wr(8'h10, 50);
    chk("R4 fire on load", {28'b0, chIrq}, 4'b0011);
  endtask

  task automatic t_gated();
    logic [31:0] v;
    doReset();
    wr(8'h1C, 32'h0);
    wr(8'h08, 3);
    tick(3);
    rd(8'h14, v); chk("R5 nothing recorded", v, 0);
    wr(8'h1C, 32'h4);
    rd(8'h14, v); chk("R5 no late set", v, 0);
    chk("R5 irq low", {28'b0, chIrq}, 0);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    doReset();
    wr(8'h1C, 32'hF);
    wr(8'h00, 1);
    wr(8'h04, 2);
    tick(2);
    chk("R6 both set", {28'b0, chIrq}, 4'b0011);
    wr(8'h14, 32'h1);
    rd(8'h14, v); chk("R6 keep unwritten", v, 2);
    chk("R6 irq0 lowered", {28'b0, chIrq}, 4'b0010);
    wr(8'h14, 32'hFFFF_FFFD);
    rd(8'h14, v); chk("R6 zero bit kept", v, 2);
    wr(8'h14, 32'hF);
    rd(8'h14, v); chk("R6 cleared", v, 0);
    // clear and new match on the same edge
    wr(8'h00, 10);
    wr(8'h10, 8);
    tick(1);
    @(negedge clk);
    tickEn = 1'b1; busAddr = 8'h14; busWdata = 32'h1; busWe = 1'b1;
    @(negedge clk);
    tickEn = 1'b0; busWe = 1'b0;
    rd(8'h14, v); chk("R6 set beats clear", v, 1);
  endtask

  task automatic t_ien();
    logic [31:0] v;
    doReset();
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, v); chk("R7 low 12 bits", v, 32'h0000_0FFF);
    wr(8'h1C, 32'h0000_5A5A);
    rd(8'h1C, v); chk("R7 pattern", v, 32'h0000_0A5A);
  endtask

  task automatic t_wdog();
    logic [31:0] v;
    int p0;
    doReset();
    wr(8'h18, 32'hABCD_0001);
    rd(8'h18, v); chk("R8 readback", v, 32'hABCD_0001);
    wr(8'h0C, 102);
    wr(8'h10, 100);
    p0 = pulseCycles;
    tick(1);
    chk("R8 no early pulse", 32'(pulseCycles - p0), 0);
    tick(1);
    repeat (3) @(negedge clk);
    chk("R8 one pulse", 32'(pulseCycles - p0), 1);
    rd(8'h18, v); chk("R8 disarmed", v, 0);
    rd(8'h14, v); chk("R8 status untouched", v, 0);
    wr(8'h18, 32'h2);
    wr(8'h10, 100);
    p0 = pulseCycles;
    tick(3);
    chk("R9 unarmed no pulse", 32'(pulseCycles - p0), 0);
    rd(8'h18, v); chk("R9 register kept", v, 2);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    doReset();
    wr(8'h1C, 32'h2);
    wr(8'h04, 1);
    wr(8'h10, 32'hFFFF_FFFE);
    tick(2);
    rd(8'h10, v); chk("R10 wrapped", v, 0);
    chk("R10 not yet", {28'b0, chIrq}, 0);
    tick(1);
    chk("R10 fires after wrap", {28'b0, chIrq}, 4'b0010);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    doReset();
    wr(8'h1C, 32'h3);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h1D, 32'hFFFF_FFFF);
    wr(8'h12, 32'h1234_5678);
    rd(8'h20, v); chk("R11 read 0x20", v, 0);
    rd(8'h1D, v); chk("R11 read misaligned", v, 0);
    rd(8'h1C, v); chk("R11 ien unchanged", v, 3);
    rd(8'h10, v); chk("R11 counter unchanged", v, 0);
    rd(8'h18, v); chk("R11 watchdog unchanged", v, 0);
  endtask

  initial begin
    t_reset();
    t_count();
    t_load();
    t_match();
    t_gated();
    t_clear();
    t_ien();
    t_wdog();
    t_wrap();
    t_unmapped();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end
endmodule